// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Write Controller

This block gives synchronous logic the write behaviour of a byte-wide parallel nonvolatile memory. Three active-low strobes (chip select, output enable, write enable), an address bus and a data-in bus are registered on every clock. Byte writes collect in a one-page buffer. A load timer restarts after every accepted byte. When it runs out, a programming phase commits the buffered bytes to an internal array, and further input is refused until that phase ends.

While the block is busy, reads do not return array contents. They return an in-band status byte. Bit 7 is the complement of bit 7 of the most recently accepted byte. Bit 6 flips on every read. Bit 5 tells a host whether the block is still loading or already programming. The `ready` output goes low for the whole programming phase. Timer lengths are parameters counted in clocks, and the data path uses separate input and output buses in place of a tri-state pad.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, `ready` is high and `dout_vld` is low.
- R2: A read access is `ce_n`=0, `oe_n`=0, `we_n`=1. `dout_vld` follows that decode with three cycles of latency. When the block is idle, `dout` returns the array byte at `addr`.
- R3: A write access is `ce_n`=0, `oe_n`=1, `we_n`=0. The address is taken in the first cycle of the access. The data is the last value present while the access is still active, so changes after the strobe ends are not stored.
- R4: `addr[PAGE_W-1:0]` selects the byte inside a page. The first byte of a load fixes the page (the upper address bits). During the load, a write to any other page is dropped and does not restart the timer.
- R5: Each accepted byte restarts the load timer. When LOAD_CYCLES clocks pass with no accepted byte, programming begins: `ready` falls LOAD_CYCLES+1 clocks after the clock that saw the write strobe end.
- R6: `ready` stays low for exactly max(PROG_CYCLES, 2^PAGE_W) clocks per programming phase, then returns high.
- R7: While busy, status bit 7 is the inverse of bit 7 of the last accepted byte. After programming, a read of that byte returns its true value.
- R8: While busy, status bit 6 reads 0 on the first read of a busy period and flips on each following read. Status bits 4 to 0 read 0.
- R9: Status bit 5 reads 0 while the load timer runs and 1 during programming.
- R10: Programming writes only the page positions loaded in this load. Other bytes of the page keep their old values.
- R11: Write accesses during programming are ignored.
- R12: While busy, a read at any address returns the status byte rather than array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or status byte |
| dout_vld | output | 1 | Read data valid |
| ready | output | 1 | Low while programming |

## Verification
The assertions check four things on every cycle:
- `dout_vld` only ever follows a genuine read decode.
- Each low period of `ready` lasts exactly the programming length, and programming is always entered from a page load.
- Array writes happen only while `ready` is low.
- The locked page stays stable through a load.

Only the bench scenarios can show the byte-level results. These are:
- the status byte values across a sequence of polls, including the toggle phase and the inverted bit 7;
- that a foreign-page byte or a byte written during programming leaves the array unchanged;
- that untouched positions of a page survive a commit;
- that data changed after the strobe ends is not stored.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } wr_state_t;
endpackage

// File: rtl/eeprom_bus_sample.sv
// Registers the asynchronous-style strobes and turns them into access events.
module eeprom_bus_sample #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              rd_on,
  output logic              rd_start,
  output logic              wr_end,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic ce_q, oe_q, we_q, rd_prev, wr_prev, wr_on;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
      addr_q  <= '0;
      din_q   <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      ce_q    <= ce_n;
      oe_q    <= oe_n;
      we_q    <= we_n;
      addr_q  <= addr;
      din_q   <= din;
      rd_prev <= rd_on;
      wr_prev <= wr_on;
      // address from the first cycle of the access
      if (wr_on && !wr_prev) wr_addr <= addr_q;
      // data keeps the last value seen while the access is active
      if (wr_on) wr_data <= din_q;
    end
  end

  assign rd_on    = !ce_q && !oe_q && we_q;
  assign wr_on    = !ce_q && oe_q && !we_q;
  assign rd_start = rd_on && !rd_prev;
  assign wr_end   = !wr_on && wr_prev;
  assign rd_addr  = addr_q;
endmodule

// File: rtl/eeprom_page_buf.sv
// One-page staging buffer with per-byte valid flags.
module eeprom_page_buf #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) valid <= '0;
    else if (wr_en) valid[wr_idx] <= 1'b1;
  end

  assign rd_data  = slot[rd_idx];
  assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/eeprom_array.sv
// Storage array: one write port, one registered read port.
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 6,
  parameter int LOAD_CYCLES = 10000,
  parameter int PROG_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              ready
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PROG_LEN   = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
  localparam int TMR_MAX    = (LOAD_CYCLES > PROG_LEN) ? LOAD_CYCLES : PROG_LEN;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic              rd_on, rd_start, wr_end;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] wr_data;

  eeprom_bus_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rd_on(rd_on), .rd_start(rd_start),
    .wr_end(wr_end), .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  wr_state_t         state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [PG_W-1:0]   page_q;
  logic              last_msb_q, tog_q;
  logic              accept, busy, commit_end, arr_we;
  logic [DATA_W-1:0] buf_rd, arr_q, stat;
  logic              buf_vld;

  assign accept = wr_end && ((state_q == ST_IDLE) ||
                  (state_q == ST_LOAD && wr_addr[ADDR_W-1:PAGE_W] == page_q));
  assign busy       = (state_q != ST_IDLE);
  assign commit_end = (state_q == ST_PROG) && (tmr_q == TMR_W'(PROG_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      page_q     <= '0;
      last_msb_q <= 1'b0;
      ready      <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOAD;
          tmr_q   <= '0;
          page_q  <= wr_addr[ADDR_W-1:PAGE_W];
        end
        ST_LOAD: begin
          if (accept) tmr_q <= '0;
          else if (tmr_q == TMR_W'(LOAD_CYCLES - 1)) begin
            state_q <= ST_PROG;
            tmr_q   <= '0;
            ready   <= 1'b0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_PROG: begin
          if (commit_end) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            ready   <= 1'b1;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (accept) last_msb_q <= wr_data[DATA_W-1];
    end
  end

  // toggle bit: cleared when idle, flipped by each read while busy
  always_ff @(posedge clk) begin
    if (rst || !busy) tog_q <= 1'b0;
    else if (rd_start) tog_q <= ~tog_q;
  end

  eeprom_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(accept), .wr_idx(wr_addr[PAGE_W-1:0]),
    .wr_data(wr_data), .clr(commit_end), .rd_idx(tmr_q[PAGE_W-1:0]),
    .rd_data(buf_rd), .rd_valid(buf_vld)
  );

  // commit walks the page one slot per clock during the first PAGE_BYTES cycles
  assign arr_we = (state_q == ST_PROG) && (tmr_q < TMR_W'(PAGE_BYTES)) && buf_vld;

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr({page_q, tmr_q[PAGE_W-1:0]}), .wdata(buf_rd),
    .raddr(rd_addr), .rdata(arr_q)
  );

  always_comb begin
    stat           = '0;
    stat[DATA_W-1] = ~last_msb_q;
    stat[DATA_W-2] = tog_q;
    stat[DATA_W-3] = (state_q == ST_PROG);
  end

  logic              rd_pend, st_sel, vld_d;
  logic [DATA_W-1:0] st_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      st_sel   <= 1'b0;
      st_val   <= '0;
      vld_d    <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      rd_pend  <= rd_start;
      vld_d    <= rd_on;
      dout_vld <= vld_d;
      if (rd_start) begin
        st_sel <= busy;
        st_val <= stat;
      end
      if (rd_pend) dout <= st_sel ? st_val : arr_q;
    end
  end
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk
  import eeprom_pkg::*;
#(
  parameter int PG_W     = 4,
  parameter int PROG_LEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ce_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            dout_vld,
  input logic            ready,
  input logic            arr_we,
  input wr_state_t       state_q,
  input logic [PG_W-1:0] page_q
);
  int low_len;

  always_ff @(posedge clk) begin
    if (rst) low_len <= 0;
    else if (!ready) low_len <= low_len + 1;
    else low_len <= 0;
  end

  AST_VLD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(!ce_n && !oe_n && we_n, 3)); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (low_len == PROG_LEN)); // R6

  AST_PROG_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> ($past(state_q) == ST_LOAD)); // R5

  AST_ARRAY_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !ready); // R10

  AST_PAGE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && $past(state_q) == ST_LOAD) |-> $stable(page_q)); // R4
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(.PG_W(PG_W), .PROG_LEN(PROG_LEN)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_vld(dout_vld), .ready(ready), .arr_we(arr_we),
  .state_q(state_q), .page_q(page_q)
);

// File: tb/eeprom_page_ctrl_tb.sv
module eeprom_page_ctrl_tb;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 6;
  localparam int LOADC  = 40;
  localparam int PROGC  = 80;
  localparam int PLEN   = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_vld, ready;

  always #5 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
                     .LOAD_CYCLES(LOADC), .PROG_CYCLES(PROGC)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .ready(ready)
  );

  int total = 0;
  int fails = 0;
  logic [DATA_W-1:0] exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // driver: push expectation, then perform the read access
  task automatic rd_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  // address and data are scrambled after their capture points (R3)
  task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    addr = ~a;
    @(negedge clk);
    we_n = 1'b1; din = ~d;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic wait_commit();
    while (ready) @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare on each new valid read
  logic vld_seen = 1'b0;
  always @(negedge clk) begin
    if (dout_vld && !vld_seen) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected read data", int'(dout), 0);
      else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(dout == e, t, int'(dout), int'(e));
      end
    end
    vld_seen = dout_vld;
  end

  // programming phase length, measured at the port (R6)
  int low_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!ready) low_cnt++;
      else if (low_cnt != 0) begin
        check(low_cnt == PLEN, "R6 busy length", low_cnt, PLEN);
        low_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    check(dout_vld == 1'b0, "R1 dout_vld after reset", int'(dout_vld), 0);

    // S0: preload page 1
    wr_byte(10'h040, 8'h55);
    wr_byte(10'h045, 8'h01);
    wr_byte(10'h046, 8'h77);
    wr_byte(10'h047, 8'h02);
    wait_commit();
    rd_byte(10'h040, 8'h55, "R2 R3 idle read 040");
    rd_byte(10'h045, 8'h01, "R2 idle read 045");
    rd_byte(10'h046, 8'h77, "R2 idle read 046");

    // S1: partial page, foreign-page byte, exact timer expiry
    wr_byte(10'h045, 8'hA5);
    wr_byte(10'h0C0, 8'hFF);
    wr_byte(10'h047, 8'h3C);
    repeat (LOADC) @(negedge clk);
    check(ready == 1'b1, "R5 still loading", int'(ready), 1);
    @(negedge clk);
    check(ready == 1'b0, "R5 programming started", int'(ready), 0);
    rd_byte(10'h000, 8'hA0, "R12 R9 R8 R7 first busy poll");
    wr_byte(10'h046, 8'h11);
    rd_byte(10'h047, 8'hE0, "R8 toggled poll");
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    rd_byte(10'h045, 8'hA5, "R10 committed 045");
    rd_byte(10'h047, 8'h3C, "R7 true value 047");
    rd_byte(10'h046, 8'h77, "R11 R10 046 untouched");
    rd_byte(10'h040, 8'h55, "R4 foreign byte dropped");

    // S2: polling during load then programming
    wr_byte(10'h080, 8'h9C);
    rd_byte(10'h080, 8'h00, "R9 load-phase poll");
    rd_byte(10'h3FF, 8'h40, "R8 R12 load-phase toggle");
    while (ready) @(negedge clk);
    rd_byte(10'h080, 8'h20, "R9 R7 prog poll");
    rd_byte(10'h080, 8'h60, "R8 prog toggle");
    while (!ready) @(negedge clk);
    repeat (2) @(negedge clk);
    rd_byte(10'h080, 8'h9C, "R7 R2 final value");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 pending reads", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule